// File: doc/BRIEF.md
# Dual Word FIFO with Threshold Requests

This block is a pair of word queues placed between a register-side agent (software) and a serial bus engine. Software writes 32-bit words into the outbound queue and the engine drains them. The engine fills the inbound queue, and software takes words from its head. Each word holds four bytes, with the first byte on the wire in bits [7:0].

A control word sets a threshold for each direction and lets software discard the contents of either queue. A status word reports how many inbound words are waiting and how many outbound slots are free. Two request outputs stay high while the programmed thresholds are met. A sticky flag records a write into a full outbound queue. Another sticky flag records a read from an empty inbound queue. Each flag is cleared when its queue is flushed.

Top module: `wfp_top`

## Requirements
- R1: After reset, the status word shows DEPTH free outbound slots and 0 inbound words. The control word reads an outbound threshold field of DEPTH-1 and an inbound field of 0. tx_req is 1, rx_req is 0, and both error flags are 0.
- R2: Words leave on eng_tx_data in the order software wrote them, bit for bit. eng_tx_data is 0 while the outbound queue is empty.
- R3: A software push while the outbound queue is full leaves the queue unchanged and sets tx_ovf from the next cycle on.
- R4: A software pop while the inbound queue is empty leaves the queue unchanged and sets rx_unf from the next cycle on.
- R5: Status word layout: bits [7:0] hold the inbound word count and bits [23:16] hold the free outbound slots. All other bits read 0.
- R6: A control write loads the inbound threshold from bits [6:4] and the outbound threshold from bits [18:16]. Each field holds the wanted level minus one. These fields read back at the same positions.
- R7: tx_req is 1 exactly while the free outbound slots are at least the outbound field plus one.
- R8: rx_req is 1 exactly while the waiting inbound words are at least the inbound field plus one.
- R9: A control write with bit 0 set (inbound) or bit 1 set (outbound) flushes that queue. The bit reads 1 for the cycle after the write and 0 after that. From then on the queue is empty and its error flag is 0.
- R10: A push and a pop in the same cycle on a full outbound queue: the pop is taken, the push is rejected as an overflow, and one slot is left free.
- R11: Any push or pop presented in the cycle while a flush bit reads 1 is discarded for that queue.
- R12: Inbound words appear on sw_rx_data in the order the engine pushed them. sw_rx_data is 0 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_tx_push | input | 1 | Software writes a word into the outbound queue |
| sw_tx_data | input | 32 | Word being written |
| sw_rx_pop | input | 1 | Software removes the head inbound word |
| sw_rx_data | output | 32 | Head inbound word (0 when empty) |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word read value |
| stat_word | output | 32 | Occupancy status |
| tx_req | output | 1 | Outbound data request |
| rx_req | output | 1 | Inbound data request |
| tx_ovf | output | 1 | Sticky outbound overflow flag |
| rx_unf | output | 1 | Sticky inbound underflow flag |
| eng_tx_pop | input | 1 | Engine takes the head outbound word |
| eng_tx_data | output | 32 | Head outbound word (0 when empty) |
| eng_tx_avail | output | 1 | Outbound queue holds at least one word |
| eng_rx_push | input | 1 | Engine writes a word into the inbound queue |
| eng_rx_data | input | 32 | Word being pushed by the engine |
| eng_rx_ready | output | 1 | Inbound queue has a free slot |

## Verification
Two events can land in the same cycle, and each pair is checked. First, a software push can meet an engine pop while the outbound queue is full. The bench drives both strobes in the same cycle and expects exactly one free slot plus a raised overflow flag. Second, a push or pop can arrive while a flush bit still reads 1. The bench issues the flush write and then drives traffic in the next cycle; it expects an empty queue and a cleared flag. A behavioural queue model is compared with every output on every cycle, including a long random mix in which both kinds of collision occur on their own.

// File: rtl/wfp_pkg.sv
package wfp_pkg;
    localparam int WORD_W      = 32;
    localparam int RXFL_BIT    = 0;
    localparam int TXFL_BIT    = 1;
    localparam int RXTRIG_LSB  = 4;
    localparam int TXTRIG_LSB  = 16;
    localparam int STAT_RX_LSB = 0;
    localparam int STAT_TX_LSB = 16;
    localparam int STAT_FLD_W  = 8;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/wfp_fifo.sv
module wfp_fifo
    import wfp_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter bit ERR_ON_WRITE = 1'b1,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  word_t         wr_data,
    input  logic          rd_en,
    output word_t         rd_data,
    output logic [CW-1:0] count,
    output logic          err
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          err;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    word_t    mem [DEPTH];
    logic     wr_ok, rd_ok, bad_op;

    assign wr_ok = wr_en && (st_q.cnt != CW'(DEPTH)) && !flush;
    assign rd_ok = rd_en && (st_q.cnt != '0) && !flush;

    generate
        if (ERR_ON_WRITE) begin : g_err_wr
            assign bad_op = wr_en && (st_q.cnt == CW'(DEPTH));
        end else begin : g_err_rd
            assign bad_op = rd_en && (st_q.cnt == '0);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (rd_ok) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(wr_ok) - CW'(rd_ok);
        if (bad_op) begin
            st_d.err = 1'b1;
        end
        if (flush) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[st_q.wp] <= wr_data;
        end
    end

    assign rd_data = (st_q.cnt != '0) ? mem[st_q.rp] : '0;
    assign count   = st_q.cnt;
    assign err     = st_q.err;
endmodule

// File: rtl/wfp_ctrl.sv
module wfp_ctrl
    import wfp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  word_t         cfg_wdata,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    output logic          flush_tx,
    output logic          flush_rx,
    output word_t         cfg_rdata,
    output word_t         stat_word,
    output logic          tx_req,
    output logic          rx_req
);
    typedef struct packed {
        logic [TW-1:0] tx_trig;
        logic [TW-1:0] rx_trig;
        logic          fl_tx;
        logic          fl_rx;
    } ctrl_st_t;

    ctrl_st_t      st_d, st_q;
    logic [CW-1:0] tx_free;
    logic          unused_wbits;

    assign unused_wbits = &{1'b0, cfg_wdata};

    always_comb begin
        st_d       = st_q;
        st_d.fl_tx = cfg_wr && cfg_wdata[TXFL_BIT];
        st_d.fl_rx = cfg_wr && cfg_wdata[RXFL_BIT];
        if (cfg_wr) begin
            st_d.tx_trig = cfg_wdata[TXTRIG_LSB +: TW];
            st_d.rx_trig = cfg_wdata[RXTRIG_LSB +: TW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tx_trig <= TW'(DEPTH - 1);
            st_q.rx_trig <= '0;
            st_q.fl_tx   <= 1'b0;
            st_q.fl_rx   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_free = CW'(DEPTH) - tx_cnt;
    assign tx_req  = ((CW+1)'(tx_free) >= (CW+1)'(st_q.tx_trig) + 1'b1);
    assign rx_req  = ((CW+1)'(rx_cnt)  >= (CW+1)'(st_q.rx_trig) + 1'b1);

    always_comb begin
        cfg_rdata                       = '0;
        cfg_rdata[TXFL_BIT]             = st_q.fl_tx;
        cfg_rdata[RXFL_BIT]             = st_q.fl_rx;
        cfg_rdata[TXTRIG_LSB +: TW]     = st_q.tx_trig;
        cfg_rdata[RXTRIG_LSB +: TW]     = st_q.rx_trig;
        stat_word                       = '0;
        stat_word[STAT_TX_LSB +: STAT_FLD_W] = STAT_FLD_W'(tx_free);
        stat_word[STAT_RX_LSB +: STAT_FLD_W] = STAT_FLD_W'(rx_cnt);
    end

    assign flush_tx = st_q.fl_tx;
    assign flush_rx = st_q.fl_rx;
endmodule

// File: rtl/wfp_top.sv
module wfp_top
    import wfp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_tx_push,
    input  logic [31:0] sw_tx_data,
    input  logic        sw_rx_pop,
    output logic [31:0] sw_rx_data,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [31:0] stat_word,
    output logic        tx_req,
    output logic        rx_req,
    output logic        tx_ovf,
    output logic        rx_unf,
    input  logic        eng_tx_pop,
    output logic [31:0] eng_tx_data,
    output logic        eng_tx_avail,
    input  logic        eng_rx_push,
    input  logic [31:0] eng_rx_data,
    output logic        eng_rx_ready
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          flush_tx, flush_rx;

    wfp_fifo #(.DEPTH(DEPTH), .ERR_ON_WRITE(1'b1)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx),
        .wr_en(sw_tx_push), .wr_data(sw_tx_data),
        .rd_en(eng_tx_pop), .rd_data(eng_tx_data),
        .count(tx_cnt), .err(tx_ovf)
    );

    wfp_fifo #(.DEPTH(DEPTH), .ERR_ON_WRITE(1'b0)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx),
        .wr_en(eng_rx_push), .wr_data(eng_rx_data),
        .rd_en(sw_rx_pop), .rd_data(sw_rx_data),
        .count(rx_cnt), .err(rx_unf)
    );

    wfp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .flush_tx(flush_tx), .flush_rx(flush_rx),
        .cfg_rdata(cfg_rdata), .stat_word(stat_word),
        .tx_req(tx_req), .rx_req(rx_req)
    );

    assign eng_tx_avail = (tx_cnt != '0);
    assign eng_rx_ready = (rx_cnt != CW'(DEPTH));
endmodule

// File: rtl/wfp_chk.sv
module wfp_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_tx_push,
    input logic        sw_rx_pop,
    input logic        eng_tx_pop,
    input logic        eng_rx_push,
    input logic        rx_flush_wr,
    input logic [31:0] cfg_rdata,
    input logic [31:0] stat_word,
    input logic        rx_req,
    input logic        tx_ovf,
    input logic        rx_unf
);
    // R9: outbound flush empties the queue and clears its flag
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[1] |=> (stat_word[23:16] == 8'(DEPTH)) && !tx_ovf);

    // R9: inbound flush bit clears itself
    p_flush_selfclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[0] && !rx_flush_wr) |=> !cfg_rdata[0]);

    // R3: push into a full outbound queue raises the flag
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[23:16] == 8'd0 && sw_tx_push && !cfg_rdata[1]) |=> tx_ovf);

    // R4: pop from an empty inbound queue raises the flag
    p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[7:0] == 8'd0 && sw_rx_pop && !cfg_rdata[0]) |=> rx_unf);

    // R5: occupancy fields stay within the depth
    p_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[7:0] <= 8'(DEPTH)) && (stat_word[23:16] <= 8'(DEPTH)));

    // R8: an empty inbound queue never requests
    p_rx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[7:0] == 8'd0) |-> !rx_req);

    // R10: outbound occupancy holds without traffic or flush
    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_tx_push && !eng_tx_pop && !cfg_rdata[1]) |=> $stable(stat_word[23:16]));

    // R12: inbound occupancy holds without traffic or flush
    p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_rx_push && !sw_rx_pop && !cfg_rdata[0]) |=> $stable(stat_word[7:0]));
endmodule

bind wfp_top wfp_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .sw_tx_push(sw_tx_push), .sw_rx_pop(sw_rx_pop),
    .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
    .rx_flush_wr(cfg_wr && cfg_wdata[0]),
    .cfg_rdata(cfg_rdata), .stat_word(stat_word),
    .rx_req(rx_req), .tx_ovf(tx_ovf), .rx_unf(rx_unf)
);

// File: tb/sim_wfp_top.sv
module sim_wfp_top;
    localparam int CLK_P = 10;
    localparam int D     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_tx_push = 0, sw_rx_pop = 0, cfg_wr = 0;
    logic        eng_tx_pop = 0, eng_rx_push = 0;
    logic [31:0] sw_tx_data = 0, cfg_wdata = 0, eng_rx_data = 0;
    logic [31:0] sw_rx_data, cfg_rdata, stat_word, eng_tx_data;
    logic        tx_req, rx_req, tx_ovf, rx_unf, eng_tx_avail, eng_rx_ready;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mtx[$];
    logic [31:0] mrx[$];
    int          m_ttrig = D - 1, m_rtrig = 0;
    bit          m_ftx = 0, m_frx = 0, m_ovf = 0, m_unf = 0;

    always #(CLK_P/2) clk = ~clk;

    wfp_top #(.DEPTH(D)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R5 status", stat_word, ((32'(D - mtx.size())) << 16) | 32'(mrx.size()));
        chk("R6 R9 control", cfg_rdata,
            (32'(m_ttrig) << 16) | (32'(m_rtrig) << 4) | (32'(m_ftx) << 1) | 32'(m_frx));
        chk("R7 tx_req", 32'(tx_req), 32'((D - mtx.size()) >= m_ttrig + 1));
        chk("R8 rx_req", 32'(rx_req), 32'(mrx.size() >= m_rtrig + 1));
        chk("R3 tx_ovf", 32'(tx_ovf), 32'(m_ovf));
        chk("R4 rx_unf", 32'(rx_unf), 32'(m_unf));
        chk("R2 eng_tx_data", eng_tx_data, (mtx.size() > 0) ? mtx[0] : 32'h0);
        chk("R12 sw_rx_data", sw_rx_data, (mrx.size() > 0) ? mrx[0] : 32'h0);
        chk("R2 eng_tx_avail", 32'(eng_tx_avail), 32'(mtx.size() > 0));
        chk("R12 eng_rx_ready", 32'(eng_rx_ready), 32'(mrx.size() < D));
    endtask

    task automatic tick();
        @(posedge clk);
        if (m_ftx) begin
            mtx.delete();
            m_ovf = 0;
        end else begin
            bit push_ok = sw_tx_push && (mtx.size() < D);
            bit pop_ok  = eng_tx_pop && (mtx.size() > 0);
            if (sw_tx_push && !push_ok) m_ovf = 1;
            if (pop_ok) void'(mtx.pop_front());
            if (push_ok) mtx.push_back(sw_tx_data);
        end
        if (m_frx) begin
            mrx.delete();
            m_unf = 0;
        end else begin
            bit push_ok = eng_rx_push && (mrx.size() < D);
            bit pop_ok  = sw_rx_pop && (mrx.size() > 0);
            if (sw_rx_pop && !pop_ok) m_unf = 1;
            if (pop_ok) void'(mrx.pop_front());
            if (push_ok) mrx.push_back(eng_rx_data);
        end
        m_ftx = cfg_wr && cfg_wdata[1];
        m_frx = cfg_wr && cfg_wdata[0];
        if (cfg_wr) begin
            m_ttrig = int'(cfg_wdata[18:16]);
            m_rtrig = int'(cfg_wdata[6:4]);
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        sw_tx_push = 0; sw_rx_pop = 0; cfg_wr = 0; eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 status", stat_word, 32'h0008_0000);
        chk("R1 control", cfg_rdata, 32'h0007_0000);
        chk("R1 tx_req", 32'(tx_req), 32'd1);
        chk("R1 rx_req", 32'(rx_req), 32'd0);
        chk("R1 flags", {30'd0, tx_ovf, rx_unf}, 32'd0);

        // fill outbound, then one too many (R3)
        for (int i = 0; i < D + 1; i++) begin
            idle(); sw_tx_push = 1; sw_tx_data = 32'hA000_0000 + 32'(i) * 32'h0101; tick();
        end
        chk("R3 overflow after full push", 32'(tx_ovf), 32'd1);

        // R10: push and pop together on full queue
        idle(); sw_tx_push = 1; sw_tx_data = 32'hDEAD_BEEF; eng_tx_pop = 1; tick();
        chk("R10 one slot free", stat_word[23:16], 32'd1);

        // drain plus extra pop on empty
        for (int i = 0; i < D + 1; i++) begin
            idle(); eng_tx_pop = 1; tick();
        end

        // R6 R8: inbound trigger at level 3
        idle(); cfg_wr = 1; cfg_wdata = (32'd7 << 16) | (32'd2 << 4); tick();
        for (int i = 0; i < 5; i++) begin
            idle(); eng_rx_push = 1; eng_rx_data = 32'h1122_3340 + 32'(i); tick();
        end
        chk("R8 rx_req at 5 words", 32'(rx_req), 32'd1);
        for (int i = 0; i < 6; i++) begin
            idle(); sw_rx_pop = 1; tick();
        end
        chk("R4 underflow after empty pop", 32'(rx_unf), 32'd1);

        // R9 R11: outbound flush with push in the pending cycle
        idle(); sw_tx_push = 1; sw_tx_data = 32'h5; tick();
        idle(); cfg_wr = 1; cfg_wdata = (32'd3 << 16) | 32'h2; tick();
        chk("R9 flush bit visible", cfg_rdata[1], 1'b1);
        idle(); sw_tx_push = 1; sw_tx_data = 32'h6; tick();
        chk("R11 push discarded in flush", stat_word[23:16], 32'd8);
        chk("R9 flag cleared", 32'(tx_ovf), 32'd0);

        // R9 R11: inbound flush with push in the pending cycle
        idle(); eng_rx_push = 1; eng_rx_data = 32'h77; tick();
        idle(); cfg_wr = 1; cfg_wdata = (32'd3 << 16) | 32'h1; tick();
        idle(); eng_rx_push = 1; eng_rx_data = 32'h78; tick();
        chk("R11 rx push discarded", stat_word[7:0], 32'd0);
        chk("R9 rx flag cleared", 32'(rx_unf), 32'd0);

        // random mix
        for (int i = 0; i < 2000; i++) begin
            idle();
            sw_tx_push  = ($urandom % 3) != 0;
            sw_tx_data  = $urandom;
            eng_tx_pop  = ($urandom % 2) != 0;
            eng_rx_push = ($urandom % 2) != 0;
            eng_rx_data = $urandom;
            sw_rx_pop   = ($urandom % 3) == 0;
            cfg_wr      = ($urandom % 20) == 0;
            cfg_wdata   = $urandom & ~(($urandom % 4 == 0) ? 32'h0 : 32'h3);
            tick();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule